// File: doc/BRIEF.md
# Serial DAC Code Receiver

This block is the digital front end of a current-output digital-to-analog converter. A host writes 16-bit frames over a three-wire link made of three signals: an active-low frame/select line, a serial clock and a serial data line. The block over-samples all three lines with a faster system clock and shifts the frame in, most significant bit first. When the frame line rises again, the block decodes the two leading command bits. For a load command, it places the data field on a parallel code output that feeds the converter core.

The width of the data field is chosen at build time through `RES_BITS`, which takes the value 8, 10, 12 or 14. The field always sits directly under the command bits. Any frame bits below the field are don't-care.

One command switches the receiver from falling-edge to rising-edge sampling. That setting stays in force until the next reset. The frame that carries the command does not touch the code output. After reset the code is zero scale and sampling uses the falling edge.

Top module: `dac_serial_frontend`

## Requirements
- R1: After reset, `dac_code` is all zeros.
- R2: A frame is the first 16 sampling edges of the serial clock while `frame_n` is low. The frame is taken MSB first. Frame bits 15:14 form the command. Frame bits 13 down to 14-RES_BITS are copied to `dac_code`, and frame bit 13 lands in the code MSB. The remaining low bits are ignored.
- R3: Command 00 loads `dac_code` when `frame_n` rises after a complete frame. At no other time does `dac_code` change.
- R4: If `frame_n` rises after fewer than 16 sampling edges, the frame is dropped. `dac_code` and the edge setting are unchanged.
- R5: Sampling edges after the 16th in the same frame are ignored.
- R6: Commands 01 and 10 leave both `dac_code` and the edge setting unchanged.
- R7: Command 11 makes every later frame sample `sdata` on the rising edge of `sclk`. The frame carrying command 11 leaves `dac_code` unchanged. The setting persists until reset.
- R8: Serial clock activity while `frame_n` is high shifts nothing and changes nothing.
- R9: Reset returns sampling to the falling edge of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sclk |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| frame_n | input | 1 | Active-low frame sync and select (asynchronous) |
| sdata | input | 1 | Serial data, MSB first (asynchronous) |
| dac_code | output | RES_BITS | Parallel code to the converter core |

## Verification
The bench drives each bit with one value ahead of the falling clock edge and the complement ahead of the rising edge. A receiver that samples on the wrong edge therefore captures the inverted word and loads a visibly wrong code. It sends truncated and over-long frames. A receiver that commits partial frames would show a partial code, and one that keeps shifting past sixteen edges would show a shifted code. It also sends reserved commands and the edge command, where a design that decodes them as loads would change the code. A reset in the middle of the run checks that the code returns to zero and the edge setting falls back to the default.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 2;

  typedef enum logic [CMD_BITS-1:0] {
    CMD_LOAD  = 2'b00,
    CMD_RSV_A = 2'b01,
    CMD_RSV_B = 2'b10,
    CMD_EDGE  = 2'b11
  } cmd_e;
endpackage

// File: rtl/dfe_rst_sync.sv
module dfe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/dfe_in_sync.sv
module dfe_in_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  assign stg_d[0] = din;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    assign stg_d[s] = stg_q[s-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/dfe_shifter.sv
module dfe_shifter #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  frame_active,
  input  logic                  samp_evt,
  input  logic                  sdi,
  output logic [FRAME_BITS-1:0] word,
  output logic                  full
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  shift_en;

  assign full     = (cnt_q == CNT_FULL);
  assign shift_en = frame_active && samp_evt && !full && !frame_start;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (frame_start) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sr_d  = {sr_q[FRAME_BITS-2:0], sdi};
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign word = sr_q;

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  p_no_shift_past_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !frame_start) |=> $stable(sr_q));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |=> $stable(sr_q));
endmodule

// File: rtl/dfe_frame_ctrl.sv
module dfe_frame_ctrl
  import dfe_pkg::*;
#(
  parameter int RES_BITS   = 14,
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_end,
  input  logic                  full,
  input  logic [FRAME_BITS-1:0] word,
  output logic [RES_BITS-1:0]   dac_code,
  output logic                  rise_mode
);
  localparam int FIELD_MSB = FRAME_BITS - CMD_BITS - 1;

  cmd_e                cmd;
  logic                commit;
  logic [RES_BITS-1:0] code_q, code_d;
  logic                mode_q, mode_d;

  assign cmd    = cmd_e'(word[FRAME_BITS-1 -: CMD_BITS]);
  assign commit = frame_end && full;

  always_comb begin
    code_d = code_q;
    mode_d = mode_q;
    if (commit) begin
      case (cmd)
        CMD_LOAD: code_d = word[FIELD_MSB -: RES_BITS];
        CMD_EDGE: mode_d = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else begin
      code_q <= code_d;
      mode_q <= mode_d;
    end
  end

  assign dac_code  = code_q;
  assign rise_mode = mode_q;

  p_code_only_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(code_q));
  p_short_frame_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !full) |=> ($stable(code_q) && $stable(mode_q)));
  p_reserved_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (word[FRAME_BITS-1] != word[FRAME_BITS-2])) |=> ($stable(code_q) && $stable(mode_q)));
  p_edge_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (cmd == CMD_EDGE)) |=> (mode_q && $stable(code_q)));
  p_edge_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> mode_q);
endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend
  import dfe_pkg::*;
#(
  parameter int RES_BITS    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                frame_n,
  input  logic                sdata,
  output logic [RES_BITS-1:0] dac_code
);
  logic                  rst_int_n;
  logic [2:0]            pins_s;
  logic                  sclk_s, frame_s, sdata_s;
  logic                  sclk_p_q, frame_p_q;
  logic                  sclk_rise, sclk_fall;
  logic                  frame_start, frame_end, frame_active;
  logic                  rise_mode, samp_evt;
  logic [FRAME_BITS-1:0] word;
  logic                  full;

  initial begin
    if (!(RES_BITS inside {8, 10, 12, 14}))
      $error("RES_BITS must be 8, 10, 12 or 14");
  end

  dfe_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n)
  );

  dfe_in_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .din({sclk, frame_n, sdata}), .dout(pins_s)
  );

  assign {sclk_s, frame_s, sdata_s} = pins_s;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sclk_p_q  <= 1'b1;
      frame_p_q <= 1'b1;
    end else begin
      sclk_p_q  <= sclk_s;
      frame_p_q <= frame_s;
    end
  end

  assign sclk_rise    = sclk_s && !sclk_p_q;
  assign sclk_fall    = !sclk_s && sclk_p_q;
  assign frame_start  = !frame_s && frame_p_q;
  assign frame_end    = frame_s && !frame_p_q;
  assign frame_active = !frame_s;
  assign samp_evt     = rise_mode ? sclk_rise : sclk_fall;

  dfe_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_int_n),
    .frame_start(frame_start), .frame_active(frame_active),
    .samp_evt(samp_evt), .sdi(sdata_s),
    .word(word), .full(full)
  );

  dfe_frame_ctrl #(.RES_BITS(RES_BITS), .FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .frame_end(frame_end), .full(full), .word(word),
    .dac_code(dac_code), .rise_mode(rise_mode)
  );

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_int_n |=> (dac_code == '0));
  p_reset_edge_r9: assert property (@(posedge clk)
    !rst_int_n |=> !rise_mode);
  p_idle_no_sample_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_s |=> $stable(dac_code) || $past(frame_end));
endmodule

// File: tb/dac_serial_frontend_tb.sv
module dac_serial_frontend_tb;
  localparam int RES = 14;
  localparam time T  = 40ns;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           sclk, frame_n, sdata;
  logic [RES-1:0] dac_code;

  typedef struct {
    logic [RES-1:0] val;
    string          tag;
  } item_t;

  item_t q[$];
  int    n_cmp  = 0;
  int    n_bad  = 0;
  bit    done   = 0;
  logic [RES-1:0] m_code;
  bit             m_rise;

  always #2ns clk = ~clk;

  dac_serial_frontend #(.RES_BITS(RES)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_n(frame_n),
    .sdata(sdata), .dac_code(dac_code)
  );

  // monitor: pop each expected item and compare with the port
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (dac_code !== it.val) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, dac_code, it.val);
      end
    end
  end

  task automatic push(string tag);
    item_t it;
    repeat (20) @(posedge clk);
    it.val = m_code;
    it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  // each bit: value b before the falling edge, ~b before the rising edge
  task automatic frame(input logic [31:0] bits, input int n, input string tag);
    logic [15:0] cap;
    sclk = 1'b1;
    frame_n = 1'b0;
    #T;
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i];  #T;
      sclk  = 1'b0;     #T;
      sdata = ~bits[i]; #T;
      sclk  = 1'b1;     #T;
    end
    frame_n = 1'b1;
    if (n >= 16) begin
      cap = bits[n-1 -: 16];
      if (m_rise) cap = ~cap;
      case (cap[15:14])
        2'b00:   m_code = cap[13 -: RES];
        2'b11:   m_rise = 1'b1;
        default: ;
      endcase
    end
    push(tag);
  endtask

  function automatic logic [31:0] ld(input logic [13:0] v);
    return {16'h0, 2'b00, v};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    m_code = '0;
    m_rise = 1'b0;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    sclk = 1'b1; frame_n = 1'b1; sdata = 1'b0;
    do_reset();
    push("R1 reset code");
    frame(ld(14'h2A5B), 16, "R2 R3 load pattern");
    frame(ld(14'h3FFF), 16, "R2 R3 all ones");
    frame(ld(14'h2000), 16, "R2 code msb");
    frame(ld(14'h0001), 16, "R2 code lsb");
    frame(32'h0000_3FFF, 10, "R4 short frame dropped");
    frame({12'h0, ld(14'h1234), 4'hF}, 20, "R5 extra bits ignored");
    for (int k = 0; k < 8; k++) begin
      sclk = 1'b0; sdata = k[0]; #T;
      sclk = 1'b1; #T;
    end
    push("R8 idle clocks ignored");
    frame({16'h0, 2'b01, 14'h0F0F}, 16, "R6 reserved 01");
    frame({16'h0, 2'b10, 14'h0F0F}, 16, "R6 reserved 10");
    frame(ld(14'h0555), 16, "R6 edge still falling");
    frame({16'h0, 2'b11, 14'h1111}, 16, "R7 edge cmd holds code");
    frame(~ld(14'h1ABC), 16, "R7 rising-edge capture");
    frame(~ld(14'h0246), 16, "R7 rising persists");
    do_reset();
    push("R1 R9 reset mid-run");
    frame(ld(14'h3210), 16, "R9 falling after reset");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #5ms;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule